// File: doc/BRIEF.md
# Slotted Ring Node

This block is one station on a one-way ring that joins small processor cores. A slot register links each node to the next, and every slot moves one hop per clock. Each cycle the node looks at the slot arriving from upstream and does one of three things. It takes the slot if the slot is addressed to it. It fills the slot with a waiting word if the slot is empty. Otherwise it passes the slot on unchanged. The node has no arbiter. A word can enter only a free slot, so the delay from sender to receiver depends only on how many hops separate them.

On the core side there are two small queues. A send queue is filled through a write strobe, and a receive queue is drained through a read strobe. The head of the receive queue is always visible on the output data bus. A two-bit status word tells the core whether the send queue is full and whether the receive queue holds data.

A slot is `SLOT_W = 1 + 2*NODE_W + DATA_W` bits wide. Bit `SLOT_W-1` is the valid flag. Below it sits the destination index, then the source index, and the payload occupies bits `DATA_W-1:0`. An empty slot has the valid flag clear. The node always emits empty slots as the fixed marker: all bits zero except the low byte, which is `8'h7E`. On input, any slot with the valid flag clear counts as empty.

Top module: `ring_node`

## Requirements
- R1: While reset is asserted, and right after it, `ring_out` carries the empty marker (low byte `8'h7E`, all other bits zero), `status` is 0 and `rd_word` is 0.
- R2: A valid incoming slot whose destination differs from `NODE_ID` appears unchanged on `ring_out` one clock later.
- R3: A valid incoming slot addressed to `NODE_ID`, arriving while the receive queue is not full, is removed from the ring: `ring_out` carries the empty marker one clock later. Its source index and payload are queued for the core.
- R4: A valid incoming slot addressed to `NODE_ID`, arriving while the receive queue is full, appears unchanged on `ring_out` one clock later.
- R5: When an empty slot arrives and the send queue is not empty, `ring_out` one clock later holds a valid slot. That slot carries the oldest queued destination and payload, with the source field equal to `NODE_ID`, and the word leaves the send queue.
- R6: When an empty slot arrives and the send queue is empty, `ring_out` one clock later carries the empty marker.
- R7: Both queues are first-in first-out. A write word is `{destination, payload}` with the destination in the upper `NODE_W` bits. A received word is `{source, payload}` in the same layout.
- R8: `status[0]` is 1 exactly when the send queue holds `TX_DEPTH` words. `status[1]` is 1 exactly when the receive queue holds at least one word. Both are updated at the clock edge that changes the queues.
- R9: A write strobe while the send queue is full, and a read strobe while the receive queue is empty, change nothing. The full check uses the queue state before the edge, even if a word leaves in the same cycle.
- R10: `rd_word` shows the head of the receive queue without any strobe, and shows 0 when that queue is empty. A read strobe advances it to the next word after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_in | input | SLOT_W | Slot arriving from the upstream node |
| ring_out | output | SLOT_W | Registered slot sent to the downstream node |
| wr_req | input | 1 | Core write strobe for the send queue |
| wr_word | input | NODE_W+DATA_W | Destination and payload to send |
| rd_req | input | 1 | Core read strobe for the receive queue |
| rd_word | output | NODE_W+DATA_W | Source and payload at the receive queue head |
| status | output | 2 | Bit 0 send queue full, bit 1 receive data present |

## Verification
The properties assume that `ring_in`, `wr_req`, `wr_word` and `rd_req` are stable around each rising edge. They also assume that every cycle presents some slot on `ring_in`, either valid or with the valid flag clear. The properties make no assumption about the slot contents. The bench changes every input only at the falling edge. It mixes slots for this node, slots for other nodes and empty slots. It also drives strobes deliberately against a full send queue and an empty receive queue, so the ignore paths and the full-queue pass-through are reached under the same timing.

// File: rtl/ring_node.sv
`timescale 1ns/1ps
module ring_node #(
  parameter int NODE_W   = 4,
  parameter int DATA_W   = 16,
  parameter int NODE_ID  = 5,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int SLOT_W  = 1 + 2*NODE_W + DATA_W,
  localparam int WORD_W  = NODE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] ring_in,
  output logic [SLOT_W-1:0] ring_out,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_word,
  output logic [1:0]        status
);
  localparam int TXP = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RXP = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int TXC = $clog2(TX_DEPTH + 1);
  localparam int RXC = $clog2(RX_DEPTH + 1);
  localparam logic [TXC-1:0] TX_MAX = TXC'(TX_DEPTH);
  localparam logic [RXC-1:0] RX_MAX = RXC'(RX_DEPTH);
  localparam logic [TXP-1:0] TX_LAST = TXP'(TX_DEPTH - 1);
  localparam logic [RXP-1:0] RX_LAST = RXP'(RX_DEPTH - 1);
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);
  localparam logic [SLOT_W-1:0] EMPTY_SLOT = SLOT_W'(8'h7E);

  logic [WORD_W-1:0] tx_mem [TX_DEPTH];
  logic [WORD_W-1:0] rx_mem [RX_DEPTH];
  logic [TXP-1:0] tx_rd, tx_wr;
  logic [RXP-1:0] rx_rd, rx_wr;
  logic [TXC-1:0] tx_cnt;
  logic [RXC-1:0] rx_cnt;
  logic [SLOT_W-1:0] slot_nxt;
  logic [WORD_W-1:0] tx_head;

  wire in_valid = ring_in[SLOT_W-1];
  wire [NODE_W-1:0] in_dst = ring_in[SLOT_W-2 -: NODE_W];
  wire [NODE_W-1:0] in_src = ring_in[SLOT_W-2-NODE_W -: NODE_W];
  wire tx_full = (tx_cnt == TX_MAX);
  wire tx_has  = (tx_cnt != '0);
  wire rx_full = (rx_cnt == RX_MAX);
  wire rx_has  = (rx_cnt != '0);
  wire take    = in_valid && (in_dst == MY_ID) && !rx_full;
  wire send    = !in_valid && tx_has;
  wire push_tx = wr_req && !tx_full;
  wire pop_rx  = rd_req && rx_has;

  assign tx_head = tx_mem[tx_rd];
  assign rd_word = rx_has ? rx_mem[rx_rd] : '0;
  assign status  = {rx_has, tx_full};

  always_comb begin
    if (take)
      slot_nxt = EMPTY_SLOT;
    else if (send)
      slot_nxt = {1'b1, tx_head[WORD_W-1 -: NODE_W], MY_ID, tx_head[DATA_W-1:0]};
    else if (in_valid)
      slot_nxt = ring_in;
    else
      slot_nxt = EMPTY_SLOT;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ring_out <= EMPTY_SLOT;
    else        ring_out <= slot_nxt;

  always_ff @(posedge clk)
    if (push_tx) tx_mem[tx_wr] <= wr_word;

  always_ff @(posedge clk)
    if (take) rx_mem[rx_wr] <= {in_src, ring_in[DATA_W-1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
    end else begin
      if (push_tx) tx_wr <= (tx_wr == TX_LAST) ? '0 : tx_wr + 1'b1;
      if (send)    tx_rd <= (tx_rd == TX_LAST) ? '0 : tx_rd + 1'b1;
      tx_cnt <= tx_cnt + TXC'(push_tx) - TXC'(send);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else begin
      if (take)   rx_wr <= (rx_wr == RX_LAST) ? '0 : rx_wr + 1'b1;
      if (pop_rx) rx_rd <= (rx_rd == RX_LAST) ? '0 : rx_rd + 1'b1;
      rx_cnt <= rx_cnt + RXC'(take) - RXC'(pop_rx);
    end
endmodule

// File: rtl/ring_node_chk.sv
`timescale 1ns/1ps
module ring_node_chk #(
  parameter int NODE_W   = 4,
  parameter int DATA_W   = 16,
  parameter int NODE_ID  = 5,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int SLOT_W  = 1 + 2*NODE_W + DATA_W,
  localparam int TXC = $clog2(TX_DEPTH + 1),
  localparam int RXC = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] ring_in,
  input logic [SLOT_W-1:0] ring_out,
  input logic [TXC-1:0]    tx_cnt,
  input logic [RXC-1:0]    rx_cnt,
  input logic [1:0]        status
);
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);
  localparam logic [SLOT_W-1:0] EMPTY_SLOT = SLOT_W'(8'h7E);
  wire in_valid = ring_in[SLOT_W-1];
  wire in_hit = in_valid && (ring_in[SLOT_W-2 -: NODE_W] == MY_ID);

  // R2
  pass_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_hit |=> ring_out == $past(ring_in));
  // R3
  take_mine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit && (rx_cnt != RXC'(RX_DEPTH)) |=> ring_out == EMPTY_SLOT && status[1]);
  // R4
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit && (rx_cnt == RXC'(RX_DEPTH)) |=> ring_out == $past(ring_in));
  // R5
  insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (tx_cnt != '0) |=> ring_out[SLOT_W-1] && ring_out[SLOT_W-2-NODE_W -: NODE_W] == MY_ID);
  // R6
  idle_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (tx_cnt == '0) |=> ring_out == EMPTY_SLOT);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TXC'(TX_DEPTH) && rx_cnt <= RXC'(RX_DEPTH));
  // R8
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> tx_cnt != '0);
endmodule

bind ring_node ring_node_chk #(
  .NODE_W(NODE_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID),
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .ring_out(ring_out),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .status(status)
);

// File: tb/sim_ring_node.sv
`timescale 1ns/1ps
module sim_ring_node;
  localparam int NODE_W = 4, DATA_W = 16, NODE_ID = 5, TXD = 4, RXD = 4;
  localparam int SLOT_W = 1 + 2*NODE_W + DATA_W;
  localparam int WORD_W = NODE_W + DATA_W;
  localparam logic [SLOT_W-1:0] EMPTY = SLOT_W'(8'h7E);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SLOT_W-1:0] ring_in = EMPTY;
  logic [SLOT_W-1:0] ring_out;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [WORD_W-1:0] wr_word = '0;
  logic [WORD_W-1:0] rd_word;
  logic [1:0] status;

  ring_node #(.NODE_W(NODE_W), .DATA_W(DATA_W), .NODE_ID(NODE_ID),
              .TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .ring_out(ring_out),
    .wr_req(wr_req), .wr_word(wr_word), .rd_req(rd_req),
    .rd_word(rd_word), .status(status));

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [WORD_W-1:0] txq[$];
  logic [WORD_W-1:0] rxq[$];
  logic [SLOT_W-1:0] exp_ring = EMPTY;
  string ring_tag = "R1", side_tag = "R1";

  function automatic logic [SLOT_W-1:0] mk(input logic v, input int d, input int s, input int p);
    return {v, NODE_W'(d), NODE_W'(s), DATA_W'(p)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); exp_ring = EMPTY; ring_tag = "R1"; side_tag = "R1";
    end else begin
      bit tx_full0, rx_full0, rx_has0, tx_has0, hit;
      tx_full0 = txq.size() == TXD; tx_has0 = txq.size() != 0;
      rx_full0 = rxq.size() == RXD; rx_has0 = rxq.size() != 0;
      hit = ring_in[SLOT_W-1] && (int'(ring_in[SLOT_W-2 -: NODE_W]) == NODE_ID);
      side_tag = "R7";
      if (hit && !rx_full0) begin
        exp_ring = EMPTY; ring_tag = "R3";
        rxq.push_back({ring_in[SLOT_W-2-NODE_W -: NODE_W], ring_in[DATA_W-1:0]});
      end else if (hit) begin
        exp_ring = ring_in; ring_tag = "R4";
      end else if (ring_in[SLOT_W-1]) begin
        exp_ring = ring_in; ring_tag = "R2";
      end else if (tx_has0) begin
        logic [WORD_W-1:0] w;
        w = txq.pop_front();
        exp_ring = {1'b1, w[WORD_W-1 -: NODE_W], NODE_W'(NODE_ID), w[DATA_W-1:0]};
        ring_tag = "R5";
      end else begin
        exp_ring = EMPTY; ring_tag = "R6";
      end
      if (wr_req && !tx_full0) txq.push_back(wr_word);
      else if (wr_req) side_tag = "R9";
      if (rd_req && rx_has0) begin void'(rxq.pop_front()); side_tag = "R10"; end
      else if (rd_req) side_tag = "R9";
    end
  end

  always @(negedge clk) begin
    logic [1:0] es;
    logic [WORD_W-1:0] ew;
    es = {rxq.size() != 0, txq.size() == TXD};
    ew = (rxq.size() != 0) ? rxq[0] : '0;
    compared++;
    if (ring_out !== exp_ring) begin
      mismatched++;
      $display("FAIL %s ring_out actual %h expected %h", ring_tag, ring_out, exp_ring);
    end
    compared++;
    if (status !== es) begin
      mismatched++;
      $display("FAIL %s/R8 status actual %b expected %b", side_tag, status, es);
    end
    compared++;
    if (rd_word !== ew) begin
      mismatched++;
      $display("FAIL %s/R10 rd_word actual %h expected %h", side_tag, rd_word, ew);
    end
  end

  task automatic step(input logic [SLOT_W-1:0] s, input logic w, input int wd, input logic r);
    @(negedge clk);
    ring_in = s; wr_req = w; wr_word = WORD_W'(wd); rd_req = r;
  endtask

  initial begin
    #(5.0 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) step(EMPTY, 1'b0, 0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R6 idle
    repeat (3) step(EMPTY, 1'b0, 0, 1'b0);
    // R2 foreign traffic
    for (int i = 0; i < 4; i++) step(mk(1, 3, 2, 16'h1000 + i), 1'b0, 0, 1'b0);
    // R9 writes beyond full while ring is busy
    for (int i = 0; i < 6; i++) step(mk(1, i % 4, 7, i), 1'b1, (((i + 8) % 16) << DATA_W) | (16'hA000 + i), 1'b0);
    // R5 R7 inserts in order, then R6
    repeat (6) step(mk(0, 0, 0, 0), 1'b0, 0, 1'b0);
    // R3 then R4 with receive queue full
    for (int i = 0; i < 6; i++) step(mk(1, NODE_ID, i + 1, 16'hB000 + i), 1'b0, 0, 1'b0);
    // R10 reads, R9 read while empty
    for (int i = 0; i < 6; i++) step(mk(1, 9, 1, i), 1'b0, 0, 1'b1);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k, d;
      k = int'($urandom % 4);
      d = (($urandom % 3) == 0) ? NODE_ID : int'($urandom % 16);
      step(k == 0 ? EMPTY : mk(k != 1, d, int'($urandom % 16), int'($urandom % 65536)),
           ($urandom % 2) == 0, int'($urandom % (1 << WORD_W)), ($urandom % 3) == 0);
    end
    repeat (8) step(EMPTY, 1'b0, 0, 1'b1);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule